// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives a successive-approximation converter through a sparse set of up to sixteen input channels. Software or a hardware trigger starts a scan. The sequencer then issues one conversion at a time to the converter, using a start pulse with a channel index. It waits for the converter's done pulse and writes each returned sample to a result slot named by the channel's index. The converter itself is outside the block and is seen only as a start/done/data handshake.

A scan can begin with two optional phases. The first is a fixed-length sampling window for dedicated sample-and-hold circuits on channels 0 to 2. The second is one diagnostic conversion of an internal reference level, whose result goes to a separate diagnostic slot. After these, every enabled channel is converted in ascending order.

In one-shot mode the busy flag clears when the scan ends. In repeat mode scans follow each other back to back until software clears the flag. An interrupt pulse marks each completed scan when it is enabled.

Top module: `adc_scan_seq`

## Requirements
- R1: Within a scan, the enabled channels (bits set in `chan_mask`) are converted in ascending index order, each exactly once, starting from the lowest set bit. At most one conversion is in flight at any time.
- R2: In one-shot mode (`repeat_mode`=0), `busy` rises one cycle after an accepted start. It falls by itself once the last enabled channel's result has been written.
- R3: In repeat mode (`repeat_mode`=1), `busy` stays high and a new scan begins right after each completed one. It falls only after a clear request on `sw_start_clr`.
- R4: With `diag_en`=1, every scan performs one diagnostic conversion before any channel conversion. This conversion has `conv_diag`=1 and `conv_level` equal to `diag_level` (0 = zero level, 1 = half reference, 2 = full reference). Its result is written with `res_diag`=1 and `res_idx`=0.
- R5: When `sh_mask & chan_mask[2:0]` is nonzero, each scan opens with a sampling phase of SH_CYCLES cycles. During this phase `sh_sample` equals that masked value and no conversion is started. If the masked value is zero, there is no sampling phase.
- R6: Each channel conversion ends in a one-cycle `res_we` pulse, one cycle after `conv_done`. The pulse carries `res_idx` equal to the converted channel, `res_diag`=0, and `res_data` equal to the converter's data.
- R7: A completed scan produces a one-cycle `scan_irq` pulse only when `irq_en`=1.
- R8: `sw_start_set` always starts a scan. With `trig_en`=1, `ext_sel`=0 selects a pulse on `sync_trig` as the hardware start. With `trig_en`=1, `ext_sel`=1 selects a rising edge of `ext_trig`, which passes through a two-stage synchronizer first. With `trig_en`=0, both hardware inputs are ignored.
- R9: A start request of any kind that arrives while `busy` is high is ignored. It does not restart the scan and does not add conversions.
- R10: A start with an empty channel mask, no diagnosis and no sampling phase completes within a few cycles. It writes no result, raises `scan_irq` if `irq_en`=1, and returns `busy` to 0.
- R11: A clear request made while a conversion is in flight takes effect when that conversion's done pulse arrives. That result is discarded and no `scan_irq` is raised for the unfinished scan.
- R12: After reset, `busy`, `conv_start`, `res_we`, `scan_irq` and `sh_sample` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_mask | input | NCH | Enabled channel bitmap |
| repeat_mode | input | 1 | 0 one-shot, 1 repeating scans |
| diag_en | input | 1 | Insert diagnostic conversion at scan start |
| diag_level | input | 2 | Diagnostic level: 0 zero, 1 half, 2 full |
| sh_mask | input | 3 | Sample-and-hold enables for channels 0..2 |
| irq_en | input | 1 | Scan-complete interrupt enable |
| trig_en | input | 1 | Allow hardware start sources |
| ext_sel | input | 1 | 0 synchronous trigger, 1 external asynchronous trigger |
| sw_start_set | input | 1 | Software start request pulse |
| sw_start_clr | input | 1 | Software clear/stop request pulse |
| sync_trig | input | 1 | Synchronous trigger pulse |
| ext_trig | input | 1 | Asynchronous external trigger level |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | DATA_W | Converter result, valid with conv_done |
| busy | output | 1 | Start/busy flag |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | IDX_W | Channel index for the conversion |
| conv_diag | output | 1 | Conversion targets the internal reference |
| conv_level | output | 2 | Diagnostic level for the converter |
| sh_sample | output | 3 | Sampling strobes, high during the sampling phase |
| res_we | output | 1 | Result write strobe |
| res_idx | output | IDX_W | Result slot index |
| res_diag | output | 1 | Result goes to the diagnostic slot |
| res_data | output | DATA_W | Result value |
| scan_irq | output | 1 | Scan-complete interrupt pulse |

## Verification
The bench builds the sequencer with the default sixteen channels and 12-bit data, and shortens SH_CYCLES to 3. With a full-width mask, the picker's top index and the cursor's carry into its extra bit are both exercised. The short sampling window lets scans that combine sampling, diagnosis and channel conversions finish quickly, so their relative order can be compared entry by entry. A converter model with a fixed three-cycle latency keeps a conversion in flight long enough to land a stop request or a second trigger inside it.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int SH_N = 3;  // channels with dedicated sample-and-hold

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEGIN,
    ST_SAMPLE,
    ST_DIAG,
    ST_NEXT,
    ST_WAIT
  } seq_state_t;

  localparam logic [1:0] LVL_ZERO = 2'd0;
  localparam logic [1:0] LVL_HALF = 2'd1;
  localparam logic [1:0] LVL_FULL = 2'd2;
endpackage

// File: rtl/adcseq_trig.sv
module adcseq_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_set,
  input  logic trig_en,
  input  logic ext_sel,
  input  logic sync_trig,
  input  logic ext_trig,
  output logic start_evt
);
  logic [SYNC_STAGES:0] ext_pipe;
  logic ext_rise;

  always_ff @(posedge clk) begin
    if (rst) ext_pipe <= '0;
    else     ext_pipe <= {ext_pipe[SYNC_STAGES-1:0], ext_trig};
  end

  assign ext_rise  = ext_pipe[SYNC_STAGES-1] & ~ext_pipe[SYNC_STAGES];
  assign start_evt = sw_set | (trig_en & (ext_sel ? ext_rise : sync_trig));
endmodule

// File: rtl/adcseq_pick.sv
module adcseq_pick #(
  parameter int NCH = 16,
  localparam int IDX_W = $clog2(NCH),
  localparam int CUR_W = IDX_W + 1
) (
  input  logic [NCH-1:0]   mask,
  input  logic [CUR_W-1:0] cursor,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [NCH-1:0] elig;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = mask[g] && (CUR_W'(g) >= cursor);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adcseq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DATA_W = 12,
  parameter int SH_CYCLES = 4,
  localparam int IDX_W = $clog2(NCH),
  localparam int CUR_W = IDX_W + 1,
  localparam int SHC_W = $clog2(SH_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    chan_mask,
  input  logic              repeat_mode,
  input  logic              diag_en,
  input  logic [1:0]        diag_level,
  input  logic [SH_N-1:0]   sh_mask,
  input  logic              irq_en,
  input  logic              trig_en,
  input  logic              ext_sel,
  input  logic              sw_start_set,
  input  logic              sw_start_clr,
  input  logic              sync_trig,
  input  logic              ext_trig,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              busy,
  output logic              conv_start,
  output logic [IDX_W-1:0]  conv_chan,
  output logic              conv_diag,
  output logic [1:0]        conv_level,
  output logic [SH_N-1:0]   sh_sample,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_idx,
  output logic              res_diag,
  output logic [DATA_W-1:0] res_data,
  output logic              scan_irq
);
  seq_state_t       state;
  logic             start_evt;
  logic             stop_req;
  logic [CUR_W-1:0] cursor;
  logic [SHC_W-1:0] sh_cnt;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic [SH_N-1:0]  sh_act;

  assign sh_act = sh_mask & chan_mask[SH_N-1:0];

  adcseq_trig #(.SYNC_STAGES(2)) u_trig (
    .clk(clk), .rst(rst), .sw_set(sw_start_set), .trig_en(trig_en),
    .ext_sel(ext_sel), .sync_trig(sync_trig), .ext_trig(ext_trig),
    .start_evt(start_evt)
  );

  adcseq_pick #(.NCH(NCH)) u_pick (
    .mask(chan_mask), .cursor(cursor), .found(pick_found), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      stop_req   <= 1'b0;
      cursor     <= '0;
      sh_cnt     <= '0;
      sh_sample  <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      conv_diag  <= 1'b0;
      conv_level <= LVL_ZERO;
      res_we     <= 1'b0;
      res_idx    <= '0;
      res_diag   <= 1'b0;
      res_data   <= '0;
      scan_irq   <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      res_we     <= 1'b0;
      scan_irq   <= 1'b0;
      if (busy && sw_start_clr) stop_req <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (start_evt) begin
            busy     <= 1'b1;
            stop_req <= 1'b0;
            state    <= ST_BEGIN;
          end
        end
        ST_BEGIN: begin
          if (stop_req) begin
            busy <= 1'b0;
            state <= ST_IDLE;
          end else begin
            cursor <= '0;
            if (|sh_act) begin
              sh_sample <= sh_act;
              sh_cnt    <= SHC_W'(SH_CYCLES - 1);
              state     <= ST_SAMPLE;
            end else if (diag_en) begin
              state <= ST_DIAG;
            end else begin
              state <= ST_NEXT;
            end
          end
        end
        ST_SAMPLE: begin
          if (stop_req) begin
            busy      <= 1'b0;
            sh_sample <= '0;
            state     <= ST_IDLE;
          end else if (sh_cnt == '0) begin
            sh_sample <= '0;
            state     <= diag_en ? ST_DIAG : ST_NEXT;
          end else begin
            sh_cnt <= sh_cnt - 1'b1;
          end
        end
        ST_DIAG: begin
          if (stop_req) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            conv_start <= 1'b1;
            conv_diag  <= 1'b1;
            conv_level <= diag_level;
            conv_chan  <= '0;
            state      <= ST_WAIT;
          end
        end
        ST_NEXT: begin
          if (stop_req) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (pick_found) begin
            conv_start <= 1'b1;
            conv_diag  <= 1'b0;
            conv_chan  <= pick_idx;
            cursor     <= CUR_W'(pick_idx) + 1'b1;
            state      <= ST_WAIT;
          end else begin
            scan_irq <= irq_en;
            if (repeat_mode) begin
              state <= ST_BEGIN;
            end else begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (stop_req) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              res_we   <= 1'b1;
              res_idx  <= conv_chan;
              res_diag <= conv_diag;
              res_data <= conv_data;
              state    <= ST_NEXT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the converter is only started while the busy flag is high
  p_conv_needs_busy_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  // R1: a start pulse is never followed directly by another one
  p_one_in_flight_r1: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R6: a result write always follows a converter done pulse
  p_write_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(conv_done));

  // R7: the interrupt pulse appears only when enabled
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    scan_irq |-> $past(irq_en));

  // R5: no conversion starts during the sampling window
  p_no_conv_sampling_r5: assert property (@(posedge clk) disable iff (rst)
    (|sh_sample) |-> !conv_start);

  // R3: in repeat mode busy only drops after a stop request
  p_repeat_holds_busy_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(repeat_mode)) |-> $past(stop_req));
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
  localparam int NCH = 16;
  localparam int DATA_W = 12;
  localparam int SH_CYC = 3;
  localparam int LAT = 3;
  localparam int NVEC = 6;
  localparam int WD_LIMIT = 100000;

  // stimulus table: mask, diag enable, level, sh mask, irq enable
  localparam logic [15:0] T_MASK [NVEC] = '{16'h0025, 16'h8001, 16'h0007, 16'hF0F0, 16'h0002, 16'hFFFF};
  localparam logic        T_DIAG [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [1:0]  T_LVL  [NVEC] = '{2'd0, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0};
  localparam logic [2:0]  T_SH   [NVEC] = '{3'b000, 3'b000, 3'b101, 3'b001, 3'b010, 3'b000};
  localparam logic        T_IRQ  [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 0;
  logic rst = 1;
  logic [NCH-1:0] chan_mask = '0;
  logic repeat_mode = 0, diag_en = 0, irq_en = 0, trig_en = 0, ext_sel = 0;
  logic [1:0] diag_level = 0;
  logic [2:0] sh_mask = 0;
  logic sw_start_set = 0, sw_start_clr = 0, sync_trig = 0, ext_trig = 0;
  logic conv_done = 0;
  logic [DATA_W-1:0] conv_data = 0;
  logic busy, conv_start, conv_diag, res_we, res_diag, scan_irq;
  logic [3:0] conv_chan, res_idx;
  logic [1:0] conv_level;
  logic [2:0] sh_sample;
  logic [DATA_W-1:0] res_data;

  adc_scan_seq #(.NCH(NCH), .DATA_W(DATA_W), .SH_CYCLES(SH_CYC)) dut_i (
    .clk(clk), .rst(rst), .chan_mask(chan_mask), .repeat_mode(repeat_mode),
    .diag_en(diag_en), .diag_level(diag_level), .sh_mask(sh_mask), .irq_en(irq_en),
    .trig_en(trig_en), .ext_sel(ext_sel), .sw_start_set(sw_start_set),
    .sw_start_clr(sw_start_clr), .sync_trig(sync_trig), .ext_trig(ext_trig),
    .conv_done(conv_done), .conv_data(conv_data), .busy(busy), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_diag(conv_diag), .conv_level(conv_level),
    .sh_sample(sh_sample), .res_we(res_we), .res_idx(res_idx), .res_diag(res_diag),
    .res_data(res_data), .scan_irq(scan_irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nlog = 0, nirq = 0, nstart = 0;
  logic [3:0] log_idx [64];
  logic log_diag [64];
  logic [DATA_W-1:0] log_data [64];
  logic sh_seen = 0, first_seen = 0, sh_before = 0;
  logic [2:0] sh_val = 0;
  logic pend = 0, pdiag = 0;
  int pcnt = 0;
  logic [3:0] pch = 0;
  logic [1:0] plvl = 0;

  function automatic logic [DATA_W-1:0] ch_data(input logic [3:0] ch);
    return {ch, 8'hA5};
  endfunction
  function automatic logic [DATA_W-1:0] lvl_data(input logic [1:0] l);
    return (l == 2'd0) ? 12'h000 : (l == 2'd1) ? 12'h800 : 12'hFFF;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // converter model and event monitor, just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
    conv_done = 0;
    if (pend) begin
      if (pcnt == 0) begin
        conv_done = 1;
        conv_data = pdiag ? lvl_data(plvl) : ch_data(pch);
        pend = 0;
      end else pcnt--;
    end
    if (conv_start) begin
      pend = 1; pcnt = LAT - 1; pch = conv_chan; pdiag = conv_diag; plvl = conv_level;
      nstart++;
      if (!first_seen) begin first_seen = 1; sh_before = sh_seen; end
    end
    if (|sh_sample) begin sh_seen = 1; sh_val = sh_sample; end
    if (res_we && nlog < 64) begin
      log_idx[nlog] = res_idx; log_diag[nlog] = res_diag; log_data[nlog] = res_data;
      nlog++;
    end
    if (scan_irq) nirq++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    nlog = 0; nirq = 0; nstart = 0; sh_seen = 0; first_seen = 0; sh_before = 0; sh_val = 0;
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_sw_set();
    sw_start_set = 1; @(negedge clk); sw_start_set = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!busy && !conv_start && !res_we && !scan_irq && sh_sample == 0, "R12 reset outputs",
          {busy, conv_start, res_we, scan_irq, sh_sample}, 0);
    rst = 0;
    @(negedge clk);

    // table walk, one-shot scans started by software
    for (int v = 0; v < NVEC; v++) begin
      int k;
      logic exp_sh;
      chan_mask = T_MASK[v]; diag_en = T_DIAG[v]; diag_level = T_LVL[v];
      sh_mask = T_SH[v]; irq_en = T_IRQ[v]; repeat_mode = 0;
      clear_logs();
      pulse_sw_set();
      check(busy, "R2 busy after start", busy, 1);
      wait_idle(500);
      repeat (2) @(negedge clk);
      check(!busy, "R2 busy clears after one-shot", busy, 0);
      k = 0;
      if (T_DIAG[v]) begin
        check(nlog > 0 && log_diag[0] && log_idx[0] == 0 && log_data[0] == lvl_data(T_LVL[v]),
              "R4 diagnostic result first", {log_diag[0], log_data[0]}, {1'b1, lvl_data(T_LVL[v])});
        k = 1;
      end
      for (int c = 0; c < NCH; c++) begin
        if (T_MASK[v][c]) begin
          check(k < nlog && !log_diag[k] && log_idx[k] == 4'(c) && log_data[k] == ch_data(4'(c)),
                "R1 R6 ascending channel result", {log_idx[k], log_data[k]}, {4'(c), ch_data(4'(c))});
          k++;
        end
      end
      check(nlog == k, "R1 result count", nlog, k);
      check(nirq == int'(T_IRQ[v]), "R7 irq count", nirq, int'(T_IRQ[v]));
      exp_sh = |(T_SH[v] & T_MASK[v][2:0]);
      check(sh_seen == exp_sh, "R5 sampling phase present", sh_seen, exp_sh);
      if (exp_sh) begin
        check(sh_before, "R5 sampling before first conversion", sh_before, 1);
        check(sh_val == (T_SH[v] & T_MASK[v][2:0]), "R5 sampling strobes", sh_val, T_SH[v] & T_MASK[v][2:0]);
      end
    end

    // R10: empty scan
    chan_mask = 0; diag_en = 0; sh_mask = 0; irq_en = 1;
    clear_logs();
    pulse_sw_set();
    repeat (4) @(negedge clk);
    check(!busy && nlog == 0 && nirq == 1, "R10 empty scan completes", {busy, 4'(nlog), 4'(nirq)}, 1);

    // R3 and R11: repeat mode, then stop in flight
    chan_mask = 16'h0003; repeat_mode = 1;
    clear_logs();
    pulse_sw_set();
    for (int i = 0; i < 300 && nirq < 2; i++) @(negedge clk);
    check(nirq >= 2 && busy, "R3 repeat keeps scanning", nirq, 2);
    begin
      int s0, l0, i0;
      s0 = nstart;
      for (int i = 0; i < 50 && nstart == s0; i++) @(negedge clk);
      sw_start_clr = 1; @(negedge clk); sw_start_clr = 0;
      l0 = nlog; i0 = nirq;
      wait_idle(50);
      repeat (3) @(negedge clk);
      check(!busy, "R3 clear stops repeat", busy, 0);
      check(nlog == l0, "R11 in-flight result discarded", nlog, l0);
      check(nirq == i0, "R11 no irq after stop", nirq, i0);
    end
    repeat_mode = 0;

    // R8 and R9: synchronous trigger start, second trigger ignored
    trig_en = 1; ext_sel = 0;
    clear_logs();
    sync_trig = 1; @(negedge clk); sync_trig = 0;
    check(busy, "R8 sync trigger starts", busy, 1);
    repeat (3) @(negedge clk);
    sync_trig = 1; sw_start_set = 1; @(negedge clk); sync_trig = 0; sw_start_set = 0;
    wait_idle(200);
    repeat (10) @(negedge clk);
    check(!busy && nlog == 2 && nstart == 2 && nirq == 1, "R9 busy trigger ignored",
          {busy, 4'(nlog), 4'(nstart), 4'(nirq)}, {1'b0, 4'd2, 4'd2, 4'd1});

    // R8: hardware triggers ignored when disabled
    trig_en = 0;
    clear_logs();
    sync_trig = 1; ext_trig = 1; @(negedge clk); sync_trig = 0;
    repeat (6) @(negedge clk);
    ext_trig = 0;
    repeat (4) @(negedge clk);
    check(!busy && nstart == 0, "R8 triggers ignored when disabled", nstart, 0);

    // R8: external asynchronous trigger
    trig_en = 1; ext_sel = 1;
    clear_logs();
    ext_trig = 1;
    for (int i = 0; i < 8 && !busy; i++) @(negedge clk);
    check(busy, "R8 external trigger starts", busy, 1);
    wait_idle(200);
    ext_trig = 0;
    repeat (3) @(negedge clk);
    check(nlog == 2 && log_idx[0] == 0 && log_idx[1] == 1, "R8 external scan results", nlog, 2);
    sync_trig = 1; @(negedge clk); sync_trig = 0;
    repeat (4) @(negedge clk);
    check(!busy, "R8 sync ignored in external select", busy, 0);

    summary();
    $finish;
  end
endmodule